// File: doc/BRIEF.md
# Thermal Trip Shutdown Latch

This block guards a die against runaway heating. Each clock it compares a digital junction-temperature code with a catastrophic trip point. The trip point is a configurable rated-maximum code plus a fixed margin, set by a parameter that defaults to 20. When the reading reaches that point, the block raises a thermal-trip flag and a request that every internal clock be stopped, so that program execution halts.

The power-good level qualifies both outputs. After power-good rises, a cycle counter sized from the clock frequency and a window in microseconds (10 by default) must expire before the trip can fire. From then on a trip latches. A falling temperature does not clear it. Only the removal of power-good clears it. If the die is still hot when power-good returns, the trip fires again once the arm window has run out. Power-good may be asynchronous and passes through a synchronizer of `SYNC_STAGES` flops. Power-good low is the only reset the block has.

Top module: `thermtrip_guard`

## Requirements
- R1: While power-good is low, `trip_o` and `clk_stop_o` read 0, whatever the temperature and limit inputs are.
- R2: With power-good high and the reading hot throughout, `trip_o` rises exactly on the SYNC_STAGES + ARM_CYCLES + 1st rising edge after power-good rises, where ARM_CYCLES = CLK_MHZ * ARM_US.
- R3: Before that edge, no trip is produced, even if the reading is hot.
- R4: A reading is hot when temp_code_i >= temp_max_i + TRIP_OFFSET, comparing unsigned values. A reading one code below that point never trips.
- R5: Once armed, a reading that becomes hot sets `trip_o` on the second rising edge after the change.
- R6: Once set, `trip_o` stays high while power-good stays high. A lower temperature or a higher limit does not clear it.
- R7: After power-good falls, both outputs clear on the SYNC_STAGES + 1st rising edge.
- R8: If the reading is still hot when power-good returns, the trip reasserts with the same timing as R2.
- R9: `clk_stop_o` equals `trip_o` in every cycle.
- R10: The margin sum is computed without wrap-around. If temp_max_i + TRIP_OFFSET exceeds the largest code, the trip never fires. If the sum equals the largest code, a reading of that code trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Power-good level; may be asynchronous |
| temp_code_i | input | TEMP_W | Unsigned junction temperature code |
| temp_max_i | input | TEMP_W | Unsigned rated maximum temperature code |
| trip_o | output | 1 | Latched thermal trip flag |
| clk_stop_o | output | 1 | Request to stop all internal clocks |

## Verification
The bench builds the block with CLK_MHZ = 2 and ARM_US = 4, giving an arm window of 8 cycles, with TEMP_W = 8, TRIP_OFFSET = 20 and SYNC_STAGES = 2. The short window lets the bench check the exact arming edge, the re-trigger after a power cycle and the clear latency, each to the cycle. The 8-bit code range lets it drive the threshold one code below and exactly at the trip point. It also drives limits whose margin sum overflows the code range and limits whose sum lands exactly on the largest code.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

  // Cycle count of the arm window; never less than one cycle.
  function automatic int unsigned arm_cycles(input int unsigned mhz, input int unsigned us);
    int unsigned n;
    n = mhz * us;
    return (n < 1) ? 1 : n;
  endfunction

  // Bits needed to hold a value without wrap.
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/thermtrip_sync.sv
module thermtrip_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk) chain[0] <= d_i;

  generate
    for (genvar s = 1; s < N; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign q_o = chain[N-1];
endmodule

// File: rtl/thermtrip_arm_timer.sv
module thermtrip_arm_timer #(
  parameter int unsigned CYCLES = 1250
) (
  input  logic clk,
  input  logic run_i,
  output logic armed_o
);
  localparam int unsigned CW = thermtrip_pkg::bits_for(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!run_i)           cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + CW'(1);
  end

  assign armed_o = (cnt == LAST);
endmodule

// File: rtl/thermtrip_compare.sv
module thermtrip_compare #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned OFFSET = 20
) (
  input  logic              clk,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] limit_i,
  output logic              hot_o
);
  localparam int unsigned OW = thermtrip_pkg::bits_for(OFFSET);
  localparam int unsigned SW = ((TEMP_W > OW) ? TEMP_W : OW) + 1;

  logic [SW-1:0] thr;

  // Widened sum: a threshold past the code range can never be reached.
  assign thr = SW'(limit_i) + SW'(OFFSET);

  always_ff @(posedge clk) hot_o <= (SW'(temp_i) >= thr);
endmodule

// File: rtl/thermtrip_latch.sv
module thermtrip_latch (
  input  logic clk,
  input  logic pg_i,
  input  logic armed_i,
  input  logic hot_i,
  output logic trip_o,
  output logic stop_o
);
  always_ff @(posedge clk) begin
    if (!pg_i) begin
      trip_o <= 1'b0;
      stop_o <= 1'b0;
    end else if (armed_i && hot_i) begin
      trip_o <= 1'b1;
      stop_o <= 1'b1;
    end
  end
endmodule

// File: rtl/thermtrip_guard.sv
module thermtrip_guard #(
  parameter int unsigned CLK_MHZ     = 125,
  parameter int unsigned ARM_US      = 10,
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned TRIP_OFFSET = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pwr_good_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic [TEMP_W-1:0] temp_max_i,
  output logic              trip_o,
  output logic              clk_stop_o
);
  localparam int unsigned ARM_CYCLES = thermtrip_pkg::arm_cycles(CLK_MHZ, ARM_US);

  logic pg_q;
  logic armed;
  logic hot_q;

  thermtrip_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .d_i (pwr_good_i),
    .q_o (pg_q)
  );

  thermtrip_arm_timer #(.CYCLES(ARM_CYCLES)) i_timer (
    .clk     (clk),
    .run_i   (pg_q),
    .armed_o (armed)
  );

  thermtrip_compare #(.TEMP_W(TEMP_W), .OFFSET(TRIP_OFFSET)) i_cmp (
    .clk     (clk),
    .temp_i  (temp_code_i),
    .limit_i (temp_max_i),
    .hot_o   (hot_q)
  );

  thermtrip_latch i_latch (
    .clk     (clk),
    .pg_i    (pg_q),
    .armed_i (armed),
    .hot_i   (hot_q),
    .trip_o  (trip_o),
    .stop_o  (clk_stop_o)
  );
endmodule

// File: rtl/thermtrip_guard_chk.sv
module thermtrip_guard_chk (
  input logic clk,
  input logic pg_q,
  input logic armed,
  input logic hot_q,
  input logic trip_o,
  input logic clk_stop_o
);
  // Checks start once power-good has been seen low, which sets every flop.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!pg_q) primed <= 1'b1;

  p_clear_on_pg_low_r7: assert property (@(posedge clk) disable iff (!primed)
    !pg_q |=> (!trip_o && !clk_stop_o));

  p_no_trip_unarmed_r3: assert property (@(posedge clk) disable iff (!primed)
    !armed |-> !trip_o);

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!primed || !pg_q)
    trip_o |=> trip_o);

  p_set_when_hot_r5: assert property (@(posedge clk) disable iff (!primed || !pg_q)
    (armed && hot_q) |=> trip_o);

  p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!primed)
    $rose(trip_o) |-> $past(armed && hot_q && pg_q));

  p_stop_matches_trip_r9: assert property (@(posedge clk) disable iff (!primed)
    $rose(trip_o) |-> $rose(clk_stop_o));
endmodule

bind thermtrip_guard thermtrip_guard_chk i_chk (
  .clk        (clk),
  .pg_q       (pg_q),
  .armed      (armed),
  .hot_q      (hot_q),
  .trip_o     (trip_o),
  .clk_stop_o (clk_stop_o)
);

// File: tb/test_thermtrip_guard.sv
module test_thermtrip_guard;
  localparam int unsigned MHZ  = 2;
  localparam int unsigned US   = 4;
  localparam int unsigned ARM  = MHZ * US;
  localparam int unsigned SYNC = 2;
  localparam int unsigned OFS  = 20;

  logic       clk = 1'b0;
  logic       pg = 1'b0;
  logic [7:0] temp = 8'd0;
  logic [7:0] tmax = 8'd60;
  logic       trip, stop;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  thermtrip_guard #(.CLK_MHZ(MHZ), .ARM_US(US), .TEMP_W(8),
                    .TRIP_OFFSET(OFS), .SYNC_STAGES(SYNC)) i_thermtrip_guard (
    .clk(clk), .pwr_good_i(pg), .temp_code_i(temp), .temp_max_i(tmax),
    .trip_o(trip), .clk_stop_o(stop)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic both(input logic exp, input string tag);
    check(trip, exp, tag);
    check(stop, exp, {tag, " R9"});
  endtask

  task automatic power_down();
    pg = 1'b0;
    tick(SYNC + 1);
  endtask

  task automatic t_reset();
    tick(5);
    both(1'b0, "R1 idle");
    temp = 8'd200;
    tick(6);
    both(1'b0, "R1 hot while unpowered");
  endtask

  task automatic t_arm();
    temp = 8'd100; tmax = 8'd60; pg = 1'b1;
    tick(SYNC + ARM);
    both(1'b0, "R3 before window");
    tick(1);
    both(1'b1, "R2 arming edge");
  endtask

  task automatic t_latch();
    temp = 8'd0; tmax = 8'd255;
    tick(10);
    both(1'b1, "R6 stays latched");
  endtask

  task automatic t_pg_fall();
    pg = 1'b0;
    tick(SYNC);
    check(trip, 1'b1, "R7 before clear edge");
    tick(1);
    both(1'b0, "R7 cleared");
  endtask

  task automatic t_retrigger();
    temp = 8'd100; tmax = 8'd60; pg = 1'b1;
    tick(SYNC + ARM);
    both(1'b0, "R8 before window");
    tick(1);
    both(1'b1, "R8 reasserted");
    power_down();
  endtask

  task automatic t_threshold();
    tmax = 8'd60; temp = 8'd79; pg = 1'b1;
    tick(SYNC + ARM + 10);
    both(1'b0, "R4 one below point");
    temp = 8'd80;
    tick(1);
    check(trip, 1'b0, "R5 one edge after hot");
    tick(1);
    both(1'b1, "R5 R4 at point");
    power_down();
  endtask

  task automatic t_range();
    tmax = 8'd240; temp = 8'd255; pg = 1'b1;
    tick(SYNC + ARM + 10);
    both(1'b0, "R10 overflowing sum");
    tmax = 8'd235;
    tick(1);
    check(trip, 1'b0, "R10 one edge after limit change");
    tick(1);
    both(1'b1, "R10 sum at top code");
    power_down();
    both(1'b0, "R7 cleared after range test");
  endtask

  initial begin
    tick(1);
    t_reset();
    t_arm();
    t_latch();
    t_pg_fall();
    t_retrigger();
    t_threshold();
    t_range();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule